// File: doc/BRIEF.md
# Downward-Growing Memory Stack Pointer Unit

This unit owns the stack pointer for a stack kept in an ordinary region of main memory. The stack fills from high addresses toward low ones. A command stream carries push and pop requests. For each one the unit moves the pointer, issues one write or one read on a memory request port, and for a pop returns the word it read on a separate response stream. The unit keeps no full or empty flags. It holds two limit registers, a lower limit and an upper limit, and compares the pointer against them.

The two checks sit at different points. A push is checked before anything moves: if the decremented pointer would fall below the lower limit, the push is dropped and an overflow trap pulse is raised. A pop moves the pointer first and then checks it one cycle later: if it now lies above the upper limit plus one, the pointer is put back, no read is issued and an underflow trap pulse is raised. Software can rewrite either limit through a plain register-write port, but a write only lands while the unit is idle.

Back-pressure works the same way on every stream. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A memory request and a pop response each stay valid, with their payload unchanged, until the receiver raises its ready. Read data returns on `mem_rvalid`, which cannot be stalled. The unit handles one operation at a time.

Top module: `mstk_ptr_unit`

## Requirements
- R1: After reset the pointer is 4001, the lower limit is 3000 and the upper limit is 4000. After reset `unit_idle` and `cmd_ready` are high, and `mem_req_valid`, `pop_valid`, `trap_ovf` and `trap_unf` are low.
- R2: A push (`cmd_pop`=0) whose pointer is above the lower limit decrements the pointer. It then issues exactly one write (`mem_we`=1) of `cmd_data` at the new pointer value.
- R3: A push whose pointer is at or below the lower limit is dropped. No write is issued, the pointer keeps its value, and `trap_ovf` is high for exactly the one cycle after the command is accepted.
- R4: A pop (`cmd_pop`=1) that passes its check issues one read (`mem_we`=0) at the old pointer value. It leaves the pointer one higher and returns the word read on `pop_data`, which gives last-in first-out order.
- R5: A pop whose incremented pointer exceeds the upper limit plus one issues no read, and the pointer goes back to its old value. `trap_unf` is high for exactly one cycle, the second cycle after the command is accepted.
- R6: A register write (`cfg_we`) with `cfg_sel`=0 loads the lower limit and with `cfg_sel`=1 loads the upper limit, taking effect only while `unit_idle` is high. A write while the unit is busy changes neither limit.
- R7: `cmd_ready` is high only while the unit is idle and `cfg_we` is low.
- R8: While `pop_valid` is high and `pop_ready` is low, `pop_valid` stays high and `pop_data` holds its value.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, direction and write data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_data | input | DW | Word to push |
| pop_valid | output | 1 | Pop response valid |
| pop_ready | input | 1 | Pop response consumed |
| pop_data | output | DW | Word returned by a pop |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 1 | 0 = lower limit, 1 = upper limit |
| cfg_wdata | input | AW | Limit value to write |
| unit_idle | output | 1 | No operation in progress |
| sp | output | AW | Current stack pointer |
| trap_ovf | output | 1 | Overflow trap pulse |
| trap_unf | output | 1 | Underflow trap pulse |

## Verification
`trap_ovf` is due on the first cycle after the edge that accepts a push, and `trap_unf` on the second cycle after the edge that accepts a pop, because a pop passes through one pointer-check register. The bench samples both at falling edges counted from the accepting edge and also checks that `trap_unf` is still low one cycle earlier. The pointer, the memory contents and the read and write counts have no fixed latency, since the memory model stalls at random. The bench therefore waits for `unit_idle` before comparing them with its model. Pop data is compared when `pop_valid` first appears and again after a random back-pressure delay.

// File: rtl/mstk_pkg.sv
package mstk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_PCHK  = 3'd2,
    ST_RD    = 3'd3,
    ST_RWAIT = 3'd4,
    ST_RESP  = 3'd5
  } mstk_state_e;

  typedef enum logic {
    LIM_LOWER = 1'b0,
    LIM_UPPER = 1'b1
  } mstk_lim_e;
endpackage

// File: rtl/mstk_limit_regs.sv
module mstk_limit_regs #(
  parameter int          AW     = 16,
  parameter logic [AW-1:0] LO_RST = AW'(3000),
  parameter logic [AW-1:0] HI_RST = AW'(4000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_val,
  input  logic          idle,
  output logic [AW-1:0] lo_lim,
  output logic [AW-1:0] hi_lim
);
  import mstk_pkg::*;

  logic lo_hit, hi_hit;

  // writes land only while no operation is in flight
  assign lo_hit = wr_en && idle && (mstk_lim_e'(wr_sel) == LIM_LOWER);
  assign hi_hit = wr_en && idle && (mstk_lim_e'(wr_sel) == LIM_UPPER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_lim <= LO_RST;
      hi_lim <= HI_RST;
    end else begin
      if (lo_hit) lo_lim <= wr_val;
      if (hi_hit) hi_lim <= wr_val;
    end
  end
endmodule

// File: rtl/mstk_bound_chk.sv
module mstk_bound_chk #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] sp_now,
  input  logic [AW-1:0] sp_moved,
  input  logic          moved_wrap,
  input  logic [AW-1:0] lo_lim,
  input  logic [AW-1:0] hi_lim,
  output logic          push_ok,
  output logic          pop_bad
);
  localparam logic [AW:0] ONE_X = (AW+1)'(1);

  logic [AW:0] ceil_x;
  logic [AW:0] moved_x;

  // sp_now - 1 >= lo_lim  <=>  sp_now > lo_lim (also excludes sp_now == 0)
  assign push_ok = sp_now > lo_lim;

  assign ceil_x  = {1'b0, hi_lim} + ONE_X;
  assign moved_x = {moved_wrap, sp_moved};
  assign pop_bad = moved_x > ceil_x;
endmodule

// File: rtl/mstk_seq.sv
module mstk_seq #(
  parameter int            AW     = 16,
  parameter int            DW     = 16,
  parameter logic [AW-1:0] SP_RST = AW'(4001)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_pop,
  input  logic [DW-1:0] cmd_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cfg_we,
  input  logic          push_ok,
  input  logic          pop_bad,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_moved,
  output logic          moved_wrap,
  output logic          idle,
  output logic          trap_ovf,
  output logic          trap_unf
);
  import mstk_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  mstk_state_e   state_q;
  logic [AW-1:0] sp_prev_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          wrap_q;
  logic          ovf_q, unf_q;
  logic          cmd_fire;

  assign idle      = (state_q == ST_IDLE);
  assign cmd_ready = idle && !cfg_we;
  assign cmd_fire  = cmd_valid && cmd_ready;

  assign sp_moved   = sp_q;
  assign moved_wrap = wrap_q;

  assign mem_req_valid = (state_q == ST_WR) || (state_q == ST_RD);
  assign mem_we        = (state_q == ST_WR);
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;

  assign pop_valid = (state_q == ST_RESP);
  assign pop_data  = rdata_q;

  assign trap_ovf = ovf_q;
  assign trap_unf = unf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sp_q      <= SP_RST;
      sp_prev_q <= SP_RST;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      wrap_q    <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (cmd_pop) begin
              // pop: move first, check on the next cycle
              {wrap_q, sp_q} <= {1'b0, sp_q} + {1'b0, ONE};
              sp_prev_q      <= sp_q;
              state_q        <= ST_PCHK;
            end else if (push_ok) begin
              sp_q    <= sp_q - ONE;
              addr_q  <= sp_q - ONE;
              wdata_q <= cmd_data;
              state_q <= ST_WR;
            end else begin
              ovf_q <= 1'b1;
            end
          end
        end
        ST_WR: begin
          if (mem_req_ready) state_q <= ST_IDLE;
        end
        ST_PCHK: begin
          wrap_q <= 1'b0;
          if (pop_bad) begin
            sp_q    <= sp_prev_q;
            unf_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= sp_prev_q;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_req_ready) state_q <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            rdata_q <= mem_rdata;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (pop_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mstk_ptr_unit.sv
module mstk_ptr_unit #(
  parameter int            AW     = 16,
  parameter int            DW     = 16,
  parameter logic [AW-1:0] BOTTOM = AW'(4000),
  parameter logic [AW-1:0] LO_RST = AW'(3000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_pop,
  input  logic [DW-1:0] cmd_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          unit_idle,
  output logic [AW-1:0] sp,
  output logic          trap_ovf,
  output logic          trap_unf
);
  localparam logic [AW-1:0] SP_RST = BOTTOM + AW'(1);

  logic [AW-1:0] lo_lim, hi_lim, sp_q, sp_moved;
  logic          moved_wrap, push_ok, pop_bad, idle;

  mstk_limit_regs #(.AW(AW), .LO_RST(LO_RST), .HI_RST(BOTTOM)) u_lim (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_sel (cfg_sel),
    .wr_val (cfg_wdata),
    .idle   (idle),
    .lo_lim (lo_lim),
    .hi_lim (hi_lim)
  );

  mstk_bound_chk #(.AW(AW)) u_chk (
    .sp_now     (sp_q),
    .sp_moved   (sp_moved),
    .moved_wrap (moved_wrap),
    .lo_lim     (lo_lim),
    .hi_lim     (hi_lim),
    .push_ok    (push_ok),
    .pop_bad    (pop_bad)
  );

  mstk_seq #(.AW(AW), .DW(DW), .SP_RST(SP_RST)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_pop       (cmd_pop),
    .cmd_data      (cmd_data),
    .pop_valid     (pop_valid),
    .pop_ready     (pop_ready),
    .pop_data      (pop_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .cfg_we        (cfg_we),
    .push_ok       (push_ok),
    .pop_bad       (pop_bad),
    .sp_q          (sp_q),
    .sp_moved      (sp_moved),
    .moved_wrap    (moved_wrap),
    .idle          (idle),
    .trap_ovf      (trap_ovf),
    .trap_unf      (trap_unf)
  );

  assign unit_idle = idle;
  assign sp        = sp_q;
endmodule

// File: rtl/mstk_ptr_sva.sv
module mstk_ptr_sva #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          unit_idle,
  input logic [AW-1:0] sp,
  input logic          trap_ovf,
  input logic          trap_unf,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          pop_valid,
  input logic          pop_ready,
  input logic [DW-1:0] pop_data
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // write goes to the already-decremented pointer
  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (mem_addr == sp));

  // a dropped push leaves the pointer where it was
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ovf |-> (sp == $past(sp)));

  // read goes to the old pointer, which is one below the moved pointer
  p_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_we) |-> (mem_addr == sp - ONE));

  // underflow restores the pointer held before the pop was accepted
  p_unf_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_unf |-> (sp == $past(sp, 2)));

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> unit_idle);

  p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_trap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_ovf && trap_unf));
endmodule

bind mstk_ptr_unit mstk_ptr_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .unit_idle     (unit_idle),
  .sp            (sp),
  .trap_ovf      (trap_ovf),
  .trap_unf      (trap_unf),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .pop_valid     (pop_valid),
  .pop_ready     (pop_ready),
  .pop_data      (pop_data)
);

// File: tb/mstk_ptr_unit_tb.sv
`timescale 1ns/1ps
module mstk_ptr_unit_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_pop = 1'b0;
  logic [DW-1:0] cmd_data = '0;
  logic pop_ready = 1'b0;
  logic mem_req_ready = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic cmd_ready, pop_valid, mem_req_valid, mem_we, unit_idle, trap_ovf, trap_unf;
  logic [DW-1:0] pop_data, mem_wdata;
  logic [AW-1:0] mem_addr, sp;

  always #2 clk = ~clk;

  mstk_ptr_unit u_dut (.*);

  // behavioural memory
  logic [DW-1:0] ram [logic [AW-1:0]];
  int wr_cnt = 0, rd_cnt = 0;
  bit stall = 1'b0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        ram[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata  <= ram.exists(mem_addr) ? ram[mem_addr] : '0;
        mem_rvalid <= 1'b1;
        rd_cnt++;
      end
    end
  end
  always @(negedge clk) mem_req_ready <= !stall && (($urandom % 4) != 0);

  // reference state
  int checks = 0, errors = 0;
  logic [AW-1:0] sp_m = 16'd4001, lo_m = 16'd3000, hi_m = 16'd4000;
  logic [DW-1:0] exp_ram [logic [AW-1:0]];

  function automatic bit ref_push_ok(logic [AW-1:0] s, logic [AW-1:0] lo);
    return s > lo;
  endfunction
  function automatic bit ref_pop_bad(logic [AW-1:0] s, logic [AW-1:0] hi);
    return ({1'b0, s} + 17'd1) > ({1'b0, hi} + 17'd1);
  endfunction
  function automatic logic [DW-1:0] ref_word(logic [AW-1:0] a);
    return exp_ram.exists(a) ? exp_ram[a] : '0;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200 && !unit_idle; i++) @(negedge clk);
  endtask

  task automatic do_cfg(bit sel, logic [AW-1:0] v);
    wait_idle();
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (sel) hi_m = v; else lo_m = v;
  endtask

  task automatic do_push(logic [DW-1:0] d);
    bit ok;
    int w0;
    wait_idle();
    ok = ref_push_ok(sp_m, lo_m);
    w0 = wr_cnt;
    cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk(trap_ovf == !ok, "R3 ovf pulse", trap_ovf, !ok);
    @(negedge clk);
    chk(trap_ovf == 1'b0, "R3 ovf single cycle", trap_ovf, 0);
    wait_idle();
    if (ok) begin
      sp_m = sp_m - 1;
      exp_ram[sp_m] = d;
      chk(sp == sp_m, "R2 sp after push", sp, sp_m);
      chk(wr_cnt == w0 + 1 && ram.exists(sp_m) && ram[sp_m] == d, "R2 write",
          ram.exists(sp_m) ? ram[sp_m] : -1, d);
    end else begin
      chk(sp == sp_m, "R3 sp kept", sp, sp_m);
      chk(wr_cnt == w0, "R3 no write", wr_cnt, w0);
    end
  endtask

  task automatic do_pop();
    bit bad;
    int r0, dly;
    logic [DW-1:0] e;
    wait_idle();
    bad = ref_pop_bad(sp_m, hi_m);
    r0 = rd_cnt;
    cmd_valid = 1'b1; cmd_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk(trap_unf == 1'b0, "R5 no early unf", trap_unf, 0);
    @(negedge clk);
    chk(trap_unf == bad, "R5 unf pulse", trap_unf, bad);
    if (bad) begin
      wait_idle();
      chk(sp == sp_m, "R5 sp restored", sp, sp_m);
      chk(rd_cnt == r0, "R5 no read", rd_cnt, r0);
    end else begin
      e = ref_word(sp_m);
      for (int i = 0; i < 200 && !pop_valid; i++) @(negedge clk);
      chk(pop_valid && pop_data == e, "R4 pop data", pop_data, e);
      dly = $urandom % 4;
      for (int i = 0; i < dly; i++) @(negedge clk);
      chk(pop_valid && pop_data == e, "R8 held under back-pressure", pop_data, e);
      pop_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      pop_ready = 1'b0;
      sp_m = sp_m + 1;
      wait_idle();
      chk(sp == sp_m, "R4 sp after pop", sp, sp_m);
      chk(rd_cnt == r0 + 1, "R4 one read", rd_cnt, r0 + 1);
    end
  endtask

  initial begin
    logic [AW-1:0] a_hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp == 16'd4001, "R1 sp reset", sp, 4001);
    chk(unit_idle && cmd_ready, "R1 idle", {unit_idle, cmd_ready}, 3);
    chk(!mem_req_valid && !pop_valid && !trap_ovf && !trap_unf, "R1 quiet outputs",
        {mem_req_valid, pop_valid, trap_ovf, trap_unf}, 0);

    // pop on empty stack: underflow (R5)
    do_pop();

    // LIFO (R2, R4)
    do_push(16'h1111); do_push(16'h2222); do_push(16'h3333);
    do_pop(); do_pop(); do_pop();

    // busy-time cfg write ignored (R6), cmd_ready low while busy (R7), request held (R9)
    wait_idle();
    stall = 1'b1;
    cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_data = 16'h5A5A;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'd4001;
    chk(cmd_ready == 1'b0, "R7 not ready while busy", cmd_ready, 0);
    a_hold = mem_addr;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    chk(mem_req_valid && mem_we && mem_addr == a_hold && a_hold == 16'd4000,
        "R9 request held", mem_addr, 4000);
    stall = 1'b0;
    wait_idle();
    sp_m = 16'd4000; exp_ram[sp_m] = 16'h5A5A;
    chk(sp == sp_m, "R2 sp after stalled push", sp, sp_m);
    do_push(16'h6B6B);   // succeeds only if lower limit unchanged (R6)
    chk(sp == 16'd3999, "R6 busy write ignored", sp, 3999);

    // upper limit via cfg_sel=1 (R6)
    do_cfg(1'b1, 16'd3999);
    do_pop();            // 3999 -> 4000, allowed
    do_pop();            // 4000 -> 4001 > 4000, underflow (R5)
    chk(sp == 16'd4000, "R6 upper limit applied", sp, 4000);
    do_cfg(1'b1, 16'd4000);
    do_pop();

    // lower limit via cfg_sel=0, overflow at the boundary (R3, R6)
    do_cfg(1'b0, 16'd3995);
    for (int i = 0; i < 7; i++) do_push(DW'(16'h0A00 + i));
    chk(sp == 16'd3995, "R3 stop at lower limit", sp, 3995);
    for (int i = 0; i < 6; i++) do_pop();

    // random mix
    do_cfg(1'b0, 16'd3990);
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 3) != 0) do_push(DW'($urandom));
      else do_pop();
    end
    while (sp_m < 16'd4001) do_pop();
    do_pop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule